// File: doc/BRIEF.md
# Tag-Clearing Store Router

This block sits on a core's store path in front of a memory that keeps one validity tag per capability-sized granule. Each accepted store is turned into a granule-wide memory write (granule address, byte enables, lane-shifted data) and, in the same cycle, a tag write for the granule it lands in. A plain data store always writes tag 0 there, because overwriting any part of a capability must make it unusable. A capability store instead writes a full granule and a tag byte whose low bit is the capability's tag. The granule address is the store address minus the remainder of the address modulo the capability size.

Conditional stores are passed to memory with a conditional flag. The memory answers success during the write cycle. The block registers that answer, issues the tag write one cycle later only on success, and reports the outcome to the requester on a one-cycle completion strobe. One fixed address is set aside for a serial transmitter. A plain, non-conditional store to it never reaches memory or the tag store. Instead, bits 31:24 of its data are latched into a transmit byte register and a written strobe is pulsed.

The capability size is a parameter of 16 or 32 bytes. Plain stores carry a size code and must be naturally aligned. Capability stores are assumed to be granule aligned.

Top module: `tagclr_store_router`

## Requirements
- R1: After reset, mem_we, tag_we, uart_written, cond_done, cond_ok and uart_byte are all 0.
- R2: A non-conditional plain store to any address other than the transmitter address raises mem_we in the cycle after it is accepted. mem_addr holds the store address rounded down to a multiple of the capability size. Only the enabled byte lanes of mem_data are meaningful, and byte lane k carries store data byte (k - offset).
- R3: In the same cycle as the R2 memory write, tag_we is 1, tag_addr equals mem_addr, and tag_byte is 8'h00.
- R4: A non-conditional plain store whose address equals the transmitter address produces no memory write and no tag write. In the next cycle uart_written pulses for one cycle, and uart_byte equals data bits 31:24. uart_byte then holds its value until the next such store.
- R5: A non-conditional capability store writes all byte enables with unshifted data. In the same cycle it writes tag_byte = {7'b0, req_tag} at the granule address. The transmitter carve-out does not apply to capability stores.
- R6: A conditional store raises mem_we with mem_cond = 1 and no tag write in that cycle. One cycle later cond_done pulses, with cond_ok equal to the mem_cond_ok value seen during the write cycle. A second store may not be accepted in the cycle right after a conditional store.
- R7: When mem_cond_ok is 0, the conditional store produces no tag write, so the granule's tag is unchanged. When it is 1, the tag write (0 for plain, {7'b0, req_tag} for capability) appears in the same cycle as cond_done.
- R8: req_size is log2 of the plain store's byte count (0 to 3 for 1, 2, 4 or 8 bytes). mem_be has exactly 2^req_size bits set, starting at bit offset = address mod capability size. The store address must be a multiple of its size.
- R9: A cycle with req_valid low produces no memory write and no transmit strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present this cycle |
| req_addr | input | AW | Byte address of the store |
| req_size | input | SIZE_W | log2 of byte count for plain stores |
| req_data | input | CAP_BYTES*8 | Store data, right-aligned for plain stores |
| req_cap | input | 1 | Capability store (full granule plus tag) |
| req_tag | input | 1 | Tag bit carried by a capability store |
| req_cond | input | 1 | Conditional store |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Granule-aligned memory address |
| mem_be | output | CAP_BYTES | Byte enables within the granule |
| mem_data | output | CAP_BYTES*8 | Lane-placed write data |
| mem_cond | output | 1 | Write is conditional |
| mem_cond_ok | input | 1 | Memory's success answer for a conditional write |
| tag_we | output | 1 | Tag write strobe |
| tag_addr | output | AW | Granule-aligned tag address |
| tag_byte | output | 8 | Tag byte, tag value in bit 0 |
| uart_byte | output | 8 | Transmit byte register |
| uart_written | output | 1 | Transmit byte written strobe |
| cond_done | output | 1 | Conditional store outcome strobe |
| cond_ok | output | 1 | Outcome of the last conditional store |

## Verification
The bench builds the block with 32-byte granules and a 40-bit address, so every byte offset up to 31 and every size code can be reached, including the last byte of a granule and an 8-byte store in the top lane. A small behavioural tagged memory of sixteen granules is attached to the ports, and it is compared after every store against a reference the bench keeps itself. Capability stores that set tags are interleaved with plain and conditional stores, so that a tag being cleared or kept is visible in that memory. A transmitter address inside the 40-bit space lets transmitter stores be mixed with memory traffic and checked for not touching it.

// File: rtl/tagclr_pkg.sv
package tagclr_pkg;

   localparam int TAG_BYTE_W = 8;

   typedef enum logic [1:0] {
      SK_IDLE  = 2'd0,
      SK_PLAIN = 2'd1,
      SK_CAP   = 2'd2,
      SK_UART  = 2'd3
   } store_kind_e;

   // Tag byte as stored ahead of granule data: tag value in bit 0.
   function automatic logic [TAG_BYTE_W-1:0] make_tag_byte(input logic tag_bit);
      return {{(TAG_BYTE_W-1){1'b0}}, tag_bit};
   endfunction

endpackage

// File: rtl/tagclr_lane_gen.sv
module tagclr_lane_gen #(
   parameter int CAP_BYTES = 16,
   parameter int SIZE_W    = 2
) (
   input  logic [$clog2(CAP_BYTES)-1:0] offset,
   input  logic [SIZE_W-1:0]            size_log2,
   input  logic                         is_cap,
   input  logic [CAP_BYTES*8-1:0]       data_in,
   output logic [CAP_BYTES-1:0]         byte_en,
   output logic [CAP_BYTES*8-1:0]       data_out
);
   localparam int OFS_W    = $clog2(CAP_BYTES);
   localparam int EW       = OFS_W + 2;
   localparam int MAX_SPAN = 1 << ((1 << SIZE_W) - 1);

   initial begin
      assert (MAX_SPAN <= CAP_BYTES)
         else $error("largest plain store exceeds one granule");
   end

   logic [EW-1:0]          lo_lane;
   logic [EW-1:0]          span;
   logic [EW-1:0]          hi_lane;
   logic [CAP_BYTES*8-1:0] shifted;

   assign lo_lane = {2'b00, offset};
   assign span    = EW'(1) << size_log2;
   assign hi_lane = lo_lane + span;
   assign shifted = data_in << {offset, 3'b000};

   for (genvar i = 0; i < CAP_BYTES; i++) begin : g_lane
      assign byte_en[i] = is_cap | ((EW'(i) >= lo_lane) && (EW'(i) < hi_lane));
      assign data_out[i*8 +: 8] = is_cap ? data_in[i*8 +: 8] : shifted[i*8 +: 8];
   end

endmodule

// File: rtl/tagclr_uart_tap.sv
module tagclr_uart_tap #(
   parameter int          AW        = 64,
   parameter logic [63:0] UART_ADDR = 64'h0000_0000_7F00_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic [AW-1:0] addr,
   input  logic          is_cap,
   input  logic          is_cond,
   input  logic [7:0]    byte_in,
   output logic          hit,
   output logic [7:0]    uart_byte,
   output logic          uart_written
);
   localparam logic [AW-1:0] MATCH = AW'(UART_ADDR);

   assign hit = valid && !is_cap && !is_cond && (addr == MATCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uart_byte    <= '0;
         uart_written <= 1'b0;
      end else begin
         uart_written <= hit;
         if (hit) uart_byte <= byte_in;
      end
   end

   assert_uart_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (uart_written && uart_byte == $past(byte_in)));

   assert_uart_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(uart_byte));

endmodule

// File: rtl/tagclr_tag_ctl.sv
module tagclr_tag_ctl
   import tagclr_pkg::*;
#(
   parameter int AW = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fire,
   input  logic                  is_cond,
   input  logic                  tag_bit,
   input  logic [AW-1:0]         gran_addr,
   input  logic                  mem_cond_ok,
   output logic                  tag_we,
   output logic [AW-1:0]         tag_addr,
   output logic [TAG_BYTE_W-1:0] tag_byte,
   output logic                  cond_done,
   output logic                  cond_ok
);
   logic                  pend;
   logic [AW-1:0]         pend_addr;
   logic [TAG_BYTE_W-1:0] pend_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_addr <= '0;
         pend_byte <= '0;
         tag_we    <= 1'b0;
         tag_addr  <= '0;
         tag_byte  <= '0;
         cond_done <= 1'b0;
         cond_ok   <= 1'b0;
      end else begin
         tag_we    <= 1'b0;
         cond_done <= pend;
         pend      <= fire && is_cond;
         if (fire && is_cond) begin
            pend_addr <= gran_addr;
            pend_byte <= make_tag_byte(tag_bit);
         end
         if (pend) cond_ok <= mem_cond_ok;
         if (fire && !is_cond) begin
            tag_we   <= 1'b1;
            tag_addr <= gran_addr;
            tag_byte <= make_tag_byte(tag_bit);
         end else if (pend && mem_cond_ok) begin
            tag_we   <= 1'b1;
            tag_addr <= pend_addr;
            tag_byte <= pend_byte;
         end
      end
   end

   // Usage rule: no store accepted right after a conditional store.
   assert_cond_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !fire);

   assert_cond_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> (cond_done && cond_ok == $past(mem_cond_ok)));

   assert_fail_keeps_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !mem_cond_ok) |=> !tag_we);

   assert_success_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && mem_cond_ok) |=> (tag_we && tag_addr == $past(pend_addr)));

endmodule

// File: rtl/tagclr_store_router.sv
module tagclr_store_router
   import tagclr_pkg::*;
#(
   parameter int          AW        = 64,
   parameter int          CAP_BYTES = 16,
   parameter int          SIZE_W    = 2,
   parameter logic [63:0] UART_ADDR = 64'h0000_0000_7F00_0000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [AW-1:0]          req_addr,
   input  logic [SIZE_W-1:0]      req_size,
   input  logic [CAP_BYTES*8-1:0] req_data,
   input  logic                   req_cap,
   input  logic                   req_tag,
   input  logic                   req_cond,
   output logic                   mem_we,
   output logic [AW-1:0]          mem_addr,
   output logic [CAP_BYTES-1:0]   mem_be,
   output logic [CAP_BYTES*8-1:0] mem_data,
   output logic                   mem_cond,
   input  logic                   mem_cond_ok,
   output logic                   tag_we,
   output logic [AW-1:0]          tag_addr,
   output logic [7:0]             tag_byte,
   output logic [7:0]             uart_byte,
   output logic                   uart_written,
   output logic                   cond_done,
   output logic                   cond_ok
);
   localparam int CAP_BITS = CAP_BYTES * 8;
   localparam int OFS_W    = $clog2(CAP_BYTES);

   initial begin
      assert (CAP_BYTES == 16 || CAP_BYTES == 32)
         else $error("capability size must be 16 or 32 bytes");
      assert (AW >= 32 && AW <= 64)
         else $error("address width out of range");
      assert ((UART_ADDR % CAP_BYTES) == 0)
         else $error("transmitter address must be granule aligned");
   end

   // Granule address: subtract the remainder modulo the capability size.
   logic [AW-1:0]       remainder;
   logic [AW-1:0]       gran_addr;
   logic [OFS_W-1:0]    offset;
   assign remainder = req_addr & AW'(CAP_BYTES - 1);
   assign gran_addr = req_addr - remainder;
   assign offset    = remainder[OFS_W-1:0];

   logic        uart_hit;
   logic        fire;
   store_kind_e kind;

   tagclr_uart_tap #(
      .AW(AW), .UART_ADDR(UART_ADDR)
   ) u_uart (
      .clk(clk), .rst_n(rst_n), .valid(req_valid), .addr(req_addr),
      .is_cap(req_cap), .is_cond(req_cond), .byte_in(req_data[31:24]),
      .hit(uart_hit), .uart_byte(uart_byte), .uart_written(uart_written)
   );

   always_comb begin
      if (!req_valid)   kind = SK_IDLE;
      else if (uart_hit) kind = SK_UART;
      else if (req_cap) kind = SK_CAP;
      else              kind = SK_PLAIN;
   end
   assign fire = (kind == SK_PLAIN) || (kind == SK_CAP);

   logic [CAP_BYTES-1:0] lane_be;
   logic [CAP_BITS-1:0]  lane_data;

   tagclr_lane_gen #(
      .CAP_BYTES(CAP_BYTES), .SIZE_W(SIZE_W)
   ) u_lanes (
      .offset(offset), .size_log2(req_size), .is_cap(req_cap),
      .data_in(req_data), .byte_en(lane_be), .data_out(lane_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we   <= 1'b0;
         mem_addr <= '0;
         mem_be   <= '0;
         mem_data <= '0;
         mem_cond <= 1'b0;
      end else begin
         mem_we   <= fire;
         mem_cond <= fire && req_cond;
         if (fire) begin
            mem_addr <= gran_addr;
            mem_be   <= lane_be;
            mem_data <= lane_data;
         end
      end
   end

   tagclr_tag_ctl #(
      .AW(AW)
   ) u_tag (
      .clk(clk), .rst_n(rst_n), .fire(fire), .is_cond(req_cond),
      .tag_bit(req_cap && req_tag), .gran_addr(gran_addr),
      .mem_cond_ok(mem_cond_ok), .tag_we(tag_we), .tag_addr(tag_addr),
      .tag_byte(tag_byte), .cond_done(cond_done), .cond_ok(cond_ok)
   );

   assert_tag_with_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_cond) |-> (tag_we && tag_addr == mem_addr));

   assert_plain_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_cap && !req_cond) |=> (tag_we && tag_byte == 8'h00));

   assert_uart_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      uart_written |-> (!mem_we && !tag_we));

   assert_cap_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_cap) |=> (&mem_be));

   assert_cond_no_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_cond) |-> !tag_we);

   assert_size_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_cap) |=> ($countones(mem_be) == (1 << $past(req_size))));

   assert_natural_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_cap) |-> ((32'(offset) & ((1 << req_size) - 1)) == 0));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!mem_we && !uart_written));

endmodule

// File: tb/tagclr_store_router_tb.sv
module tagclr_store_router_tb;
   localparam int          CLK_PERIOD = 10;
   localparam int          AW   = 40;
   localparam int          CB   = 32;
   localparam int          SW   = 2;
   localparam int          OW   = 5;
   localparam int          NGR  = 16;
   localparam logic [63:0] UADR = 64'h7F00_0000;
   localparam logic [AW-1:0] BASE = 40'h1000;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_cap = 0, req_tag = 0, req_cond = 0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_size = '0;
   logic [CB*8-1:0] req_data = '0;
   logic mem_we, mem_cond, tag_we, uart_written, cond_done, cond_ok;
   logic [AW-1:0] mem_addr, tag_addr;
   logic [CB-1:0] mem_be;
   logic [CB*8-1:0] mem_data;
   logic [7:0] tag_byte, uart_byte;
   logic sc_ok = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tagclr_store_router #(.AW(AW), .CAP_BYTES(CB), .SIZE_W(SW), .UART_ADDR(UADR)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_data(req_data), .req_cap(req_cap), .req_tag(req_tag),
      .req_cond(req_cond), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_data(mem_data), .mem_cond(mem_cond), .mem_cond_ok(sc_ok), .tag_we(tag_we),
      .tag_addr(tag_addr), .tag_byte(tag_byte), .uart_byte(uart_byte),
      .uart_written(uart_written), .cond_done(cond_done), .cond_ok(cond_ok));

   // Behavioural tagged memory on the block's ports.
   logic [CB*8-1:0] mdl_mem [NGR];
   logic            mdl_tag [NGR];
   logic [CB*8-1:0] ref_mem [NGR];
   logic            ref_tag [NGR];

   always @(posedge clk) begin
      if (mem_we && (!mem_cond || sc_ok))
         for (int b = 0; b < CB; b++)
            if (mem_be[b]) mdl_mem[mem_addr[OW+3:OW]][b*8 +: 8] <= mem_data[b*8 +: 8];
      if (tag_we) mdl_tag[tag_addr[OW+3:OW]] <= tag_byte[0];
   end

   int n_chk = 0, n_bad = 0;
   logic [7:0] last_uart = 8'h00;

   task automatic chk(input bit good, input string req, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [CB-1:0] exp_be(input int off, input int sz, input bit cap);
      logic [CB-1:0] r = '0;
      for (int b = 0; b < CB; b++) r[b] = cap || (b >= off && b < off + (1 << sz));
      return r;
   endfunction

   function automatic logic [CB*8-1:0] exp_lanes(input logic [CB*8-1:0] d, input int off, input int sz, input bit cap);
      logic [CB*8-1:0] r = '0;
      for (int b = 0; b < CB; b++)
         if (cap) r[b*8 +: 8] = d[b*8 +: 8];
         else if (b >= off && b < off + (1 << sz)) r[b*8 +: 8] = d[(b-off)*8 +: 8];
      return r;
   endfunction

   task automatic run_op(input bit cap, input bit cond, input bit to_uart, input int gi,
                         input int off, input int sz, input logic [CB*8-1:0] d,
                         input bit tg, input bit ok);
      logic [AW-1:0] a, gaddr;
      logic [CB-1:0] be;
      logic [CB*8-1:0] ln;
      logic [7:0] tb_byte;
      a = to_uart ? AW'(UADR) : BASE + AW'(gi*CB + off);
      gaddr = a - (a % CB);
      be = exp_be(off, sz, cap);
      ln = exp_lanes(d, off, sz, cap);
      tb_byte = {7'b0, cap & tg};
      @(negedge clk);
      req_valid = 1; req_addr = a; req_size = SW'(sz); req_data = d;
      req_cap = cap; req_tag = tg; req_cond = cond; sc_ok = ok;
      @(negedge clk);
      req_valid = 0; req_cap = 0; req_cond = 0; req_tag = 0;
      if (to_uart) begin
         chk(!mem_we && !tag_we, "R4 no mem/tag write", {mem_we, tag_we}, 0);
         chk(uart_written == 1, "R4 uart_written", uart_written, 1);
         chk(uart_byte == d[31:24], "R4 uart_byte", uart_byte, d[31:24]);
         last_uart = d[31:24];
      end else begin
         chk(uart_written == 0, "R4 no strobe", uart_written, 0);
         chk(uart_byte == last_uart, "R4 uart_byte held", uart_byte, last_uart);
         chk(mem_we == 1, "R2 mem_we", mem_we, 1);
         chk(mem_addr == gaddr, "R2 mem_addr", mem_addr, gaddr);
         chk(mem_be == be, "R8 mem_be", mem_be, be);
         chk((mem_data & ln) == ln && ((mem_data ^ ln) & exp_lanes({(CB*8){1'b1}}, off, sz, cap)) == 0,
             "R2 mem_data lanes", mem_data, ln);
         chk(mem_cond == cond, "R6 mem_cond", mem_cond, cond);
         if (cond) chk(tag_we == 0, "R6 no tag in write cycle", tag_we, 0);
         else begin
            chk(tag_we == 1 && tag_addr == gaddr, cap ? "R5 tag addr" : "R3 tag addr", tag_addr, gaddr);
            chk(tag_byte == tb_byte, cap ? "R5 tag byte" : "R3 tag byte", tag_byte, tb_byte);
         end
      end
      @(negedge clk);
      chk(mem_we == 0 && uart_written == 0, "R9 idle quiet", {mem_we, uart_written}, 0);
      if (cond && !to_uart) begin
         chk(cond_done == 1 && cond_ok == ok, "R6 cond_done/cond_ok", {cond_done, cond_ok}, {1'b1, ok});
         chk(tag_we == ok, "R7 tag on success only", tag_we, ok);
         if (ok) chk(tag_addr == gaddr && tag_byte == tb_byte, "R7 tag value", {tag_addr, tag_byte}, {gaddr, tb_byte});
      end else begin
         chk(cond_done == 0 && tag_we == 0, "R6 no stray done/tag", {cond_done, tag_we}, 0);
      end
      if (!to_uart && (!cond || ok)) begin
         for (int b = 0; b < CB; b++) if (be[b]) ref_mem[gi][b*8 +: 8] = ln[b*8 +: 8];
         ref_tag[gi] = cap & tg;
      end
      @(negedge clk);
      if (!to_uart) begin
         chk(mdl_mem[gi] == ref_mem[gi], cond ? "R7 memory data" : "R2 memory data", mdl_mem[gi], ref_mem[gi]);
         chk(mdl_tag[gi] == ref_tag[gi], cap ? "R5 memory tag" : "R3 memory tag", mdl_tag[gi], ref_tag[gi]);
      end
   endtask

   function automatic logic [CB*8-1:0] rnd_data();
      logic [CB*8-1:0] r;
      for (int w = 0; w < CB/4; w++) r[w*32 +: 32] = $urandom;
      return r;
   endfunction

   initial begin
      for (int g = 0; g < NGR; g++) begin
         mdl_mem[g] = '0; mdl_tag[g] = 0; ref_mem[g] = '0; ref_tag[g] = 0;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!mem_we && !tag_we && !uart_written && !cond_done && !cond_ok && uart_byte == 0,
          "R1 reset state", {mem_we, tag_we, uart_written, cond_done, cond_ok, uart_byte}, 0);
      // Directed corners.
      run_op(1, 0, 0, 3, 0, 0, rnd_data(), 1, 0);      // R5 set tag
      run_op(0, 0, 0, 3, 31, 0, rnd_data(), 0, 0);     // R3 last byte clears tag
      run_op(1, 0, 0, 4, 0, 0, rnd_data(), 1, 0);
      run_op(0, 1, 0, 4, 8, 3, rnd_data(), 0, 0);      // R7 failing cond keeps tag
      run_op(0, 1, 0, 4, 24, 3, rnd_data(), 0, 1);     // R7 succeeding cond clears tag
      run_op(1, 1, 0, 5, 0, 0, rnd_data(), 1, 1);      // R6 cap cond sets tag
      run_op(0, 0, 1, 0, 0, 2, rnd_data(), 0, 0);      // R4 transmitter
      run_op(1, 0, 0, 6, 0, 0, rnd_data(), 1, 0);
      run_op(0, 0, 0, 6, 0, 0, rnd_data(), 0, 0);      // R8 size 0 at lane 0
      run_op(0, 0, 0, 7, 24, 3, rnd_data(), 0, 0);     // R8 top 8-byte lane
      // Random mix.
      for (int n = 0; n < 300; n++) begin
         int k, sz, off, gi;
         bit cap, cnd;
         k  = $urandom % 8;
         gi = $urandom % NGR;
         sz = $urandom % 4;
         off = ($urandom % (CB >> sz)) << sz;
         cap = (k == 1 || k == 2);
         cnd = ($urandom % 4) == 0;
         if (k == 0) run_op(0, 0, 1, 0, 0, 2, rnd_data(), 0, 0);
         else run_op(cap, cnd, 0, gi, cap ? 0 : off, sz, rnd_data(), $urandom % 2, $urandom % 2);
      end
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule